// File: doc/BRIEF.md
# Frame Pulse Format Detector

This block watches a single master frame pulse, sampled on the master clock, and works out which of two serial-bus framing conventions the line is using. In one convention the line idles high and the frame pulse is a single-clock low level. In the other it idles low and the pulse is a single-clock high level. The detector picks out an isolated one-clock level and reads the polarity from it. It then checks that pulses of that polarity recur at the configured frame length.

The switch core must not start until the framing is known. The block therefore holds its ready signal low until two complete frame intervals with a consistent format have been seen since reset. After that it freewheels: it issues a one-cycle frame-start strobe at every frame boundary and drives two divided clocks and two frame pulses, one pair at full rate and one at half rate, for devices further down the line. A pulse that arrives in the wrong place, or an expected pulse that never arrives, does not disturb the running timing. Either event sets a sticky error flag.

Top module: `frame_fmt_detect`

## Requirements
- R1: After reset, `ready_o` is 0. It rises in the same cycle as `frame_start_o`, two clock edges after the edge that samples the third pulse of a run of pulses spaced exactly FRAME_LEN clocks apart and of equal polarity. That is the end of the second complete frame interval.
- R2: Once high, `ready_o` stays high and `fmt_gci_o` holds its value until the next reset.
- R3: When `ready_o` is 1, `fmt_gci_o` is 0 if the line idles high with active-low pulses, and 1 if the line idles low with active-high pulses.
- R4: `frame_start_o` is 0 while `ready_o` is 0. Once ready, it is a one-cycle strobe repeating every FRAME_LEN clocks. Its phase is fixed by the pulse that completed detection.
- R5: Before ready, a pulse at the wrong spacing restarts detection from that pulse, and a missing pulse returns the block to hunting. Neither sets `err_o`.
- R6: After ready, a pulse at a position other than the frame boundary sets `err_o`, visible three cycles after the edge that sampled it. A missing boundary pulse also sets `err_o`, visible three cycles after the edge where the pulse was due. In both cases `frame_start_o` keeps its FRAME_LEN period and phase.
- R7: `err_o` is 0 after reset and, once set, stays 1 until reset.
- R8: `clk_full_o` (period 2 clocks) and `clk_half_o` (period 4 clocks) are 0 while not ready. Once ready, both are 0 in the frame-start cycle. `clk_full_o` toggles every clock, and `clk_half_o` is 1 in the third and fourth clocks of each group of four.
- R9: `fp_full_o` and `fp_half_o` are 1 while not ready. Once ready, each is at its active level for the first 2 (full) or 4 (half) clocks of every frame and at the opposite level otherwise. The active level equals `fmt_gci_o` (0 for active-low, 1 for active-high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Master frame pulse line |
| fmt_gci_o | output | 1 | Detected format: 0 active-low pulse, 1 active-high pulse |
| frame_start_o | output | 1 | One-cycle strobe at each frame boundary once ready |
| ready_o | output | 1 | Format settled, switching may start |
| err_o | output | 1 | Sticky frame pulse timing error |
| clk_full_o | output | 1 | Derived clock, master clock divided by 2 |
| clk_half_o | output | 1 | Derived clock, master clock divided by 4 |
| fp_full_o | output | 1 | Frame pulse two master clocks wide |
| fp_half_o | output | 1 | Frame pulse four master clocks wide |

## Verification
On every cycle, the embedded properties check the following: ready and the error flag are sticky, the format is frozen once ready, the strobe spacing is exactly one frame, the full-rate clock toggles, and the derived frame pulse sits at the detected active level at each boundary. Other behaviours appear only over a whole stimulus sequence, and only the bench scenarios can show them. These are the exact cycle in which ready rises, the restart of detection after a misplaced or missing pulse before lock, and the three-cycle latency of the error flag after a bad or absent pulse. The bench runs them for both line polarities, with random lead-in lengths and random error positions.

// File: rtl/fpfd_pkg.sv
package fpfd_pkg;

   typedef enum logic [1:0] {
      LK_HUNT  = 2'd0,
      LK_CHECK = 2'd1,
      LK_RUN   = 2'd2
   } lock_state_e;

   localparam int unsigned NUM_RATES = 2;

endpackage

// File: rtl/fpfd_sampler.sv
module fpfd_sampler #(
   parameter int unsigned HIST = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fp_i,
   output logic pulse_o,
   output logic level_o
);

   if (HIST != 3) begin : g_bad_hist
      $error("fpfd_sampler: HIST must be 3");
   end

   logic [HIST-1:0] hist_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q <= '0;
      else         hist_q <= {hist_q[HIST-2:0], fp_i};
   end

   // middle tap differs from both neighbours -> isolated single-clock level
   assign pulse_o = (hist_q[1] != hist_q[2]) && (hist_q[0] == hist_q[2]);
   assign level_o = hist_q[1];

   a_r5_pulse_isolated : assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/fpfd_lock.sv
module fpfd_lock
   import fpfd_pkg::*;
#(
   parameter int unsigned FRAME_LEN     = 64,
   parameter int unsigned SETTLE_FRAMES = 2,
   localparam int unsigned PW = $clog2(FRAME_LEN),
   localparam int unsigned SW = $clog2(SETTLE_FRAMES + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          pulse_i,
   input  logic          level_i,
   output logic [PW-1:0] pos_o,
   output logic          ready_o,
   output logic          fmt_o,
   output logic          err_o
);

   localparam logic [PW-1:0] LAST_POS = PW'(FRAME_LEN - 1);
   localparam logic [SW-1:0] LAST_OK  = SW'(SETTLE_FRAMES - 1);

   lock_state_e   state_q;
   logic [PW-1:0] pos_q;
   logic [SW-1:0] nok_q;
   logic          cand_q;
   logic          ready_q;
   logic          err_q;
   logic          at_end;
   logic          good_pulse;

   assign at_end     = (pos_q == LAST_POS);
   assign good_pulse = pulse_i && at_end && (level_i == cand_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= LK_HUNT;
         pos_q   <= '0;
         nok_q   <= '0;
         cand_q  <= 1'b0;
         ready_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            LK_HUNT: begin
               pos_q <= '0;
               nok_q <= '0;
               if (pulse_i) begin
                  cand_q  <= level_i;
                  state_q <= LK_CHECK;
               end
            end
            LK_CHECK: begin
               if (pulse_i) begin
                  pos_q <= '0;
                  if (good_pulse) begin
                     if (nok_q == LAST_OK) begin
                        state_q <= LK_RUN;
                        ready_q <= 1'b1;
                     end else begin
                        nok_q <= nok_q + 1'b1;
                     end
                  end else begin
                     cand_q <= level_i;
                     nok_q  <= '0;
                  end
               end else if (at_end) begin
                  pos_q   <= '0;
                  nok_q   <= '0;
                  state_q <= LK_HUNT;
               end else begin
                  pos_q <= pos_q + 1'b1;
               end
            end
            LK_RUN: begin
               pos_q <= at_end ? '0 : pos_q + 1'b1;
               if ((pulse_i && !good_pulse) || (at_end && !pulse_i))
                  err_q <= 1'b1;
            end
            default: state_q <= LK_HUNT;
         endcase
      end
   end

   assign pos_o   = pos_q;
   assign ready_o = ready_q;
   assign fmt_o   = cand_q;
   assign err_o   = err_q;

   a_r2_ready_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |=> ready_o);
   a_r2_fmt_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
      ready_o |=> $stable(fmt_o));
   a_r1_ready_on_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ready_o) |-> $past(pulse_i));
   a_r7_err_sticky : assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);
   a_r5_no_err_before_ready : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_o) |-> $past(ready_o));

endmodule

// File: rtl/fpfd_rate_gen.sv
module fpfd_rate_gen
   import fpfd_pkg::*;
#(
   parameter int unsigned PW = 6
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [PW-1:0]        pos_i,
   input  logic                 ready_i,
   input  logic                 fmt_i,
   output logic [NUM_RATES-1:0] clk_o,
   output logic [NUM_RATES-1:0] fp_o,
   output logic                 frame_start_o
);

   if (PW < NUM_RATES + 1) begin : g_bad_pw
      $error("fpfd_rate_gen: position counter too narrow");
   end

   for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
      localparam logic [PW-1:0] WIDTH = PW'(2 << r);
      assign clk_o[r] = ready_i & pos_i[r];
      assign fp_o[r]  = ready_i ? ((pos_i < WIDTH) ? fmt_i : ~fmt_i) : 1'b1;
   end

   assign frame_start_o = ready_i && (pos_i == '0);

   a_r8_full_toggles : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ready_i && $past(ready_i)) |-> (clk_o[0] != $past(clk_o[0])));
   a_r8_idle_low : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ready_i |-> (clk_o == '0));

endmodule

// File: rtl/frame_fmt_detect.sv
module frame_fmt_detect
   import fpfd_pkg::*;
#(
   parameter int unsigned FRAME_LEN     = 64,
   parameter int unsigned SETTLE_FRAMES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic fp_i,
   output logic fmt_gci_o,
   output logic frame_start_o,
   output logic ready_o,
   output logic err_o,
   output logic clk_full_o,
   output logic clk_half_o,
   output logic fp_full_o,
   output logic fp_half_o
);

   localparam int unsigned PW = $clog2(FRAME_LEN);

   if (FRAME_LEN < 8 || (FRAME_LEN % 4) != 0) begin : g_bad_len
      $error("frame_fmt_detect: FRAME_LEN must be a multiple of 4, at least 8");
   end
   if (SETTLE_FRAMES < 1) begin : g_bad_settle
      $error("frame_fmt_detect: SETTLE_FRAMES must be at least 1");
   end

   logic                 pulse;
   logic                 level;
   logic [PW-1:0]        pos;
   logic [NUM_RATES-1:0] dclk;
   logic [NUM_RATES-1:0] dfp;

   fpfd_sampler #(.HIST(3)) u_sampler (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fp_i    (fp_i),
      .pulse_o (pulse),
      .level_o (level)
   );

   fpfd_lock #(
      .FRAME_LEN     (FRAME_LEN),
      .SETTLE_FRAMES (SETTLE_FRAMES)
   ) u_lock (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pulse_i (pulse),
      .level_i (level),
      .pos_o   (pos),
      .ready_o (ready_o),
      .fmt_o   (fmt_gci_o),
      .err_o   (err_o)
   );

   fpfd_rate_gen #(.PW(PW)) u_rate (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .pos_i         (pos),
      .ready_i       (ready_o),
      .fmt_i         (fmt_gci_o),
      .clk_o         (dclk),
      .fp_o          (dfp),
      .frame_start_o (frame_start_o)
   );

   assign clk_full_o = dclk[0];
   assign clk_half_o = dclk[1];
   assign fp_full_o  = dfp[0];
   assign fp_half_o  = dfp[1];

   // frame spacing monitor
   logic [PW:0] gap_q;
   logic        seen_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (frame_start_o) begin
         gap_q  <= (PW+1)'(1);
         seen_q <= 1'b1;
      end else if (seen_q && gap_q != '1) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   a_r4_frame_period : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_start_o && seen_q) |-> (gap_q == (PW+1)'(FRAME_LEN)));
   a_r4_strobe_needs_ready : assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o |-> ready_o);
   a_r9_pulse_active_at_start : assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o |-> (fp_full_o == fmt_gci_o && fp_half_o == fmt_gci_o));

endmodule

// File: tb/frame_fmt_detect_bench.sv
`timescale 1ns/1ps
module frame_fmt_detect_bench;

   localparam int FL = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fp = 1'b1;
   logic fmt, fs, rdy, err, cf, ch, ff, fh;

   always #2.5 clk = ~clk;

   frame_fmt_detect #(.FRAME_LEN(FL), .SETTLE_FRAMES(2)) u_frame_fmt_detect (
      .clk_i(clk), .rst_ni(rst_n), .fp_i(fp),
      .fmt_gci_o(fmt), .frame_start_o(fs), .ready_o(rdy), .err_o(err),
      .clk_full_o(cf), .clk_half_o(ch), .fp_full_o(ff), .fp_half_o(fh)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic o_fmt, o_fs, o_rdy, o_err, o_cf, o_ch, o_ff, o_fh;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // sample outputs after the previous edge, then drive the next input bit
   task automatic step(input logic v);
      @(negedge clk);
      o_fmt = fmt; o_fs = fs; o_rdy = rdy; o_err = err;
      o_cf = cf; o_ch = ch; o_ff = ff; o_fh = fh;
      fp = v;
   endtask

   task automatic do_reset(input bit gci);
      fp = ~gci;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(~gci);
      chk("R1 ready after reset", o_rdy, 0);
      chk("R7 err after reset", o_err, 0);
      chk("R4 strobe after reset", o_fs, 0);
      chk("R8 clocks after reset", {o_cf, o_ch}, 0);
      chk("R9 pulses after reset", {o_ff, o_fh}, 3);
   endtask

   // frames start with the pulse at j=0; F counts consistent frames sent
   task automatic run_frames(input bit gci, input int nf, input int f0,
                             input int skip_f, input int bad_f, input int bad_j);
      bit early = 1'b0;
      for (int f = 0; f < nf; f++) begin
         int F = f0 + f;
         for (int j = 0; j < FL; j++) begin
            logic v = ~gci;
            if (j == 0 && F != skip_f) v = gci;
            if (F == bad_f && j == bad_j) v = gci;
            step(v);
            if (F < 2 || (F == 2 && j < 3)) early |= o_rdy | o_fs;
            if (F == 2) begin
               if (j == 3) begin
                  chk("R1 ready rises", o_rdy, 1);
                  chk("R3 format", o_fmt, gci);
                  chk("R4 first strobe", o_fs, 1);
                  chk("R8 clocks at start", {o_cf, o_ch}, 0);
                  chk("R9 pulses at start", {o_ff, o_fh}, {gci, gci});
               end
               if (j == 4) chk("R8 clocks pos1", {o_cf, o_ch}, 2);
               if (j == 5) begin
                  chk("R8 clocks pos2", {o_cf, o_ch}, 1);
                  chk("R9 full ends half holds", {o_ff, o_fh}, {~gci, gci});
               end
               if (j == 7) chk("R9 half ends", {o_ff, o_fh}, {~gci, ~gci});
            end
            if (F > 2 && j == 3) chk("R4 periodic strobe", o_fs, 1);
            if (F > 2 && j == 4) chk("R4 strobe one cycle", o_fs, 0);
            if (F == bad_f && j == bad_j + 2) chk("R6 err before bad", o_err, 0);
            if (F == bad_f && j == bad_j + 3) chk("R6 err after bad", o_err, 1);
            if (F == skip_f && j == 2) chk("R6 err before missing", o_err, 0);
            if (F == skip_f && j == 3) chk("R6 err after missing", o_err, 1);
         end
      end
      if (f0 == 0) chk("R1 no early ready", early, 0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      // directed: active-low lock, then error-free operation
      do_reset(1'b0);
      repeat (4) step(1'b1);
      run_frames(1'b0, 4, 0, -1, -1, 0);
      chk("R7 no spurious err", o_err, 0);

      // directed: misplaced pulse before lock restarts detection
      do_reset(1'b1);
      repeat (5) step(1'b0);
      step(1'b1);
      repeat (FL + 9) step(1'b0);
      step(1'b1);
      repeat (FL / 2) step(1'b0);
      run_frames(1'b1, 3, 0, -1, -1, 0);
      chk("R5 restart without err", o_err, 0);

      // random rounds with error injection after lock
      for (int r = 0; r < 8; r++) begin
         bit gci = 1'($urandom_range(0, 1));
         int lead = $urandom_range(3, 9);
         int bj = $urandom_range(5, FL - 6);
         do_reset(gci);
         repeat (lead) step(~gci);
         if (r % 2 == 0) run_frames(gci, 5, 0, -1, 3, bj);
         else            run_frames(gci, 5, 0, 3, -1, 0);
         chk("R7 err stays set", o_err, 1);
         chk("R2 ready stays set", o_rdy, 1);
         chk("R2 format held", o_fmt, gci);
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R4 watchdog act=%0d exp=%0d", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule